// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local interrupt lines and produces two requests for a processor: a normal interrupt and a fast interrupt. Software controls it through a 32-bit word-addressed register port. It can set enable bits with one register and clear them with another, so no read-modify-write is needed. It can read the masked pending state in several views. It can also route any single source straight to the fast output.

The normal output is the OR of every source whose level and enable bit are both high. The fast output ignores the enable masks: when the fast route is on, it carries the raw level of the one chosen source. Both outputs are registered. They reflect an input level change or a register write on the next rising clock edge. All inputs are taken to be synchronous to the clock.

Register word offsets (byte address, bits 1:0 zero): 0x00 summary pending, 0x04 pending for peripheral sources 0–31, 0x08 pending for sources 32–63, 0x0C fast-route control, 0x10/0x14/0x18 enable-set for low/high/local, 0x1C/0x20/0x24 enable-clear for low/high/local.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: `irq_o` is 1 exactly when some peripheral source has its level and enable bit both 1, or some local source has its level and enable bit both 1.
- R2: A write to 0x10, 0x14 or 0x18 ORs the written bits into the enable mask of peripheral sources 0–31, peripheral sources 32–63, or the local sources. For the local bank only data bits 7:0 take effect.
- R3: A write to 0x1C, 0x20 or 0x24 clears every enable bit of the matching bank whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A read of 0x10/0x14/0x18 returns the corresponding enable mask, with zeros above bit 7 for the local bank. A read of 0x1C/0x20/0x24 returns the bitwise inverse of that same 32-bit value.
- R5: A read of 0x04 returns level AND enable for peripheral sources 0–31. A read of 0x08 returns the same for sources 32–63, where bit n stands for source 32+n.
- R6: A read of 0x00 returns the summary word. Bits 7:0 are the masked local sources. Bit 8 is 1 when any masked peripheral source 0–31 is set. Bit 9 is 1 when any masked source 32–63 is set. Bits 10 to 20 carry the masked state of peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 31:21 are zero.
- R7: A write to 0x0C loads a 7-bit source select from data bits 6:0 and the fast-route enable from bit 7. A read of 0x0C returns the enable in bit 7 and the select in bits 6:0.
- R8: With the fast route enabled, `fiq_o` equals the raw level of the selected source, regardless of the enable masks. Select 0–63 names a peripheral source and select 64–71 names local source (select−64). With the route disabled, `fiq_o` is 0.
- R9: A select value from 72 to 127 names no source, so `fiq_o` stays 0 even with the route enabled.
- R10: Both outputs are registered. A change on the level inputs or a register write shows on `irq_o`/`fiq_o` after the next rising clock edge and not before it.
- R11: A synchronous active-low reset clears both enable masks, the fast-route enable and the select, and drives both outputs to 0.
- R12: A write to a pending register, to an unmapped word, or to an address with bits 1:0 nonzero changes no state. Reads of unmapped words return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| periph_lvl | input | 64 | Peripheral interrupt levels |
| local_lvl | input | 8 | Local interrupt levels |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The levels are held at one fixed mix: a low-half source, a high-half source, several of the mirrored summary sources, and two local bits. The masks are then walked through empty, low bank only, both banks, and local only. This pattern shows whether the summary bits and the two bank flags come from the right half. It also shows whether the normal output follows the masked sources rather than the raw levels. The fast route is tried on a local select, a set peripheral select and its clear neighbour, two out-of-range selects, and with the route turned off. Together these show that the route ignores the masks and indexes the correct bank. A one-cycle input change is checked both before and after the edge to confirm the latency.

// File: rtl/irqc_pkg.sv
// Package: shared sizes, register word indices and the summary mirror list
// for the two-bank level interrupt controller.
package irqc_pkg;
    localparam int WORD_W   = 32;   // bus data width and peripheral half size
    localparam int LOC_N    = 8;    // local source count
    localparam int FSEL_W   = 7;    // fast-route select width
    localparam int BYTE_AW  = 9;    // byte address width of the register window
    localparam int MIRROR_N = 11;   // peripheral bits copied into summary

    // Register word indices (byte offset / 4)
    localparam int W_SUMMARY = 0;
    localparam int W_PEND_LO = 1;
    localparam int W_PEND_HI = 2;
    localparam int W_FAST    = 3;
    localparam int W_SET_LO  = 4;
    localparam int W_SET_HI  = 5;
    localparam int W_SET_LOC = 6;
    localparam int W_CLR_LO  = 7;
    localparam int W_CLR_HI  = 8;
    localparam int W_CLR_LOC = 9;

    // Peripheral source copied into summary bit (LOC_N + 2 + i)
    function automatic int mirror_src(input int i);
        case (i)
            0:  return 7;
            1:  return 9;
            2:  return 10;
            3:  return 18;
            4:  return 19;
            5:  return 53;
            6:  return 54;
            7:  return 55;
            8:  return 56;
            9:  return 57;
            default: return 62;
        endcase
    endfunction
endpackage

// File: rtl/irqc_mask_regs.sv
// Module: irqc_mask_regs
// Holds the peripheral and local enable masks and the fast-route control.
// Decodes word-aligned writes: set registers OR bits in, clear registers
// clear bits. Any other address is ignored. Exposes both the current state
// and the next state, so that the output stage can register a write's
// effect on the same edge that stores it.
// Assumes: one write per cycle, addresses in bytes, reset synchronous low.
module irqc_mask_regs
    import irqc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int LOCAL_N = LOC_N,
    parameter int SEL_W = FSEL_W,
    parameter int ADDR_W = BYTE_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   pen_q,
    output logic [LOCAL_N-1:0]    len_q,
    output logic                  fen_q,
    output logic [SEL_W-1:0]      fsel_q,
    output logic [2*DATA_W-1:0]   pen_d,
    output logic [LOCAL_N-1:0]    len_d,
    output logic                  fen_d,
    output logic [SEL_W-1:0]      fsel_d
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;
    logic hit_set_lo, hit_set_hi, hit_set_loc;
    logic hit_clr_lo, hit_clr_hi, hit_clr_loc, hit_fast;
    logic any_hit;

    // Split byte address into word index and alignment flag
    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    // Per-register write strobes
    always_comb begin
        hit_set_lo  = wr_en && aligned && (widx == WIDX_W'(W_SET_LO));
        hit_set_hi  = wr_en && aligned && (widx == WIDX_W'(W_SET_HI));
        hit_set_loc = wr_en && aligned && (widx == WIDX_W'(W_SET_LOC));
        hit_clr_lo  = wr_en && aligned && (widx == WIDX_W'(W_CLR_LO));
        hit_clr_hi  = wr_en && aligned && (widx == WIDX_W'(W_CLR_HI));
        hit_clr_loc = wr_en && aligned && (widx == WIDX_W'(W_CLR_LOC));
        hit_fast    = wr_en && aligned && (widx == WIDX_W'(W_FAST));
        any_hit     = hit_set_lo | hit_set_hi | hit_set_loc | hit_clr_lo
                    | hit_clr_hi | hit_clr_loc | hit_fast;
    end

    // Next-state of masks and fast control from the decoded write
    always_comb begin
        pen_d  = pen_q;
        len_d  = len_q;
        fen_d  = fen_q;
        fsel_d = fsel_q;
        if (hit_set_lo)  pen_d[DATA_W-1:0]        = pen_q[DATA_W-1:0] | wdata;
        if (hit_set_hi)  pen_d[2*DATA_W-1:DATA_W] = pen_q[2*DATA_W-1:DATA_W] | wdata;
        if (hit_set_loc) len_d                    = len_q | wdata[LOCAL_N-1:0];
        if (hit_clr_lo)  pen_d[DATA_W-1:0]        = pen_q[DATA_W-1:0] & ~wdata;
        if (hit_clr_hi)  pen_d[2*DATA_W-1:DATA_W] = pen_q[2*DATA_W-1:DATA_W] & ~wdata;
        if (hit_clr_loc) len_d                    = len_q & ~wdata[LOCAL_N-1:0];
        if (hit_fast) begin
            fsel_d = wdata[SEL_W-1:0];
            fen_d  = wdata[SEL_W];
        end
    end

    // State registers with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_q  <= '0;
            len_q  <= '0;
            fen_q  <= 1'b0;
            fsel_q <= '0;
        end else begin
            pen_q  <= pen_d;
            len_q  <= len_d;
            fen_q  <= fen_d;
            fsel_q <= fsel_d;
        end
    end

    // R2
    set_lo_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set_lo |=> ((pen_q[DATA_W-1:0] & $past(wdata)) == $past(wdata)));
    // R3
    clr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr_hi |=> ((pen_q[2*DATA_W-1:DATA_W] & $past(wdata)) == '0));
    // R12
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !any_hit) |=> ($stable(pen_q) && $stable(len_q)
                                 && $stable(fen_q) && $stable(fsel_q)));
endmodule

// File: rtl/irqc_read_mux.sv
// Module: irqc_read_mux
// Combinational read port. It forms the masked pending vectors, the summary
// word, the enable/inverse-enable views and the fast control readback.
// Assumes: word-aligned reads; misaligned or unmapped addresses read zero.
module irqc_read_mux
    import irqc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int LOCAL_N = LOC_N,
    parameter int SEL_W = FSEL_W,
    parameter int ADDR_W = BYTE_AW
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*DATA_W-1:0] plvl,
    input  logic [LOCAL_N-1:0]  llvl,
    input  logic [2*DATA_W-1:0] pen_q,
    input  logic [LOCAL_N-1:0]  len_q,
    input  logic                fen_q,
    input  logic [SEL_W-1:0]    fsel_q,
    output logic [DATA_W-1:0]   rdata
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam int MIR_LO = LOCAL_N + 2;

    logic [2*DATA_W-1:0] ppend;
    logic [LOCAL_N-1:0]  lpend;
    logic [DATA_W-1:0]   summary;
    logic [DATA_W-1:0]   loc_en_w;
    logic [DATA_W-1:0]   fast_w;
    logic [WIDX_W-1:0]   widx;

    assign widx = addr[ADDR_W-1:2];

    // Masked pending per source
    assign ppend = plvl & pen_q;
    assign lpend = llvl & len_q;

    // Summary word: local bits, bank-nonzero flags, mirrored peripheral bits
    always_comb begin
        summary = '0;
        summary[LOCAL_N-1:0] = lpend;
        summary[LOCAL_N]     = |ppend[DATA_W-1:0];
        summary[LOCAL_N+1]   = |ppend[2*DATA_W-1:DATA_W];
        for (int i = 0; i < MIRROR_N; i++) begin
            summary[MIR_LO+i] = ppend[mirror_src(i)];
        end
    end

    // Zero-extended local mask and fast control words
    always_comb begin
        loc_en_w = '0;
        loc_en_w[LOCAL_N-1:0] = len_q;
        fast_w = '0;
        fast_w[SEL_W-1:0] = fsel_q;
        fast_w[SEL_W]     = fen_q;
    end

    // Address select of the read word
    always_comb begin
        rdata = '0;
        if (addr[1:0] == 2'b00) begin
            case (widx)
                WIDX_W'(W_SUMMARY): rdata = summary;
                WIDX_W'(W_PEND_LO): rdata = ppend[DATA_W-1:0];
                WIDX_W'(W_PEND_HI): rdata = ppend[2*DATA_W-1:DATA_W];
                WIDX_W'(W_FAST):    rdata = fast_w;
                WIDX_W'(W_SET_LO):  rdata = pen_q[DATA_W-1:0];
                WIDX_W'(W_SET_HI):  rdata = pen_q[2*DATA_W-1:DATA_W];
                WIDX_W'(W_SET_LOC): rdata = loc_en_w;
                WIDX_W'(W_CLR_LO):  rdata = ~pen_q[DATA_W-1:0];
                WIDX_W'(W_CLR_HI):  rdata = ~pen_q[2*DATA_W-1:DATA_W];
                WIDX_W'(W_CLR_LOC): rdata = ~loc_en_w;
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_out_stage.sv
// Module: irqc_out_stage
// Computes the normal and fast requests from the live levels and the
// next-state masks, and registers them. This gives one edge of latency for
// both level changes and register writes.
// Assumes: select values beyond the last source pick nothing.
module irqc_out_stage #(
    parameter int PERIPH_N = 64,
    parameter int LOCAL_N = 8,
    parameter int SEL_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIPH_N-1:0] plvl,
    input  logic [LOCAL_N-1:0]  llvl,
    input  logic [PERIPH_N-1:0] pen_d,
    input  logic [LOCAL_N-1:0]  len_d,
    input  logic                fen_d,
    input  logic [SEL_W-1:0]    fsel_d,
    output logic                irq_o,
    output logic                fiq_o
);
    localparam int SRC_N = PERIPH_N + LOCAL_N;

    logic irq_next;
    logic pick;
    logic fiq_next;

    // Any masked source asserted
    assign irq_next = (|(plvl & pen_d)) | (|(llvl & len_d));

    // Raw level of the selected source, no masks applied
    always_comb begin
        pick = 1'b0;
        for (int i = 0; i < PERIPH_N; i++) begin
            if (fsel_d == SEL_W'(i)) pick = plvl[i];
        end
        for (int j = 0; j < LOCAL_N; j++) begin
            if (fsel_d == SEL_W'(PERIPH_N + j)) pick = llvl[j];
        end
    end

    assign fiq_next = fen_d & pick;

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= irq_next;
            fiq_o <= fiq_next;
        end
    end

    // R1
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((plvl & pen_d) == '0) && ((llvl & len_d) == '0)) |=> !irq_o);
    // R8
    fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fen_d |=> !fiq_o);
    // R9
    fast_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fen_d && (int'(fsel_d) >= SRC_N)) |=> !fiq_o);
    // R8
    fast_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fen_d && (int'(fsel_d) == PERIPH_N) && llvl[0]) |=> fiq_o);
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Module: lvl_irq_ctrl (top)
// Two-bank level interrupt controller: enable masks with separate set and
// clear registers, pending views on a combinational read port, and a
// registered normal output and single-source fast output.
// Assumes: all inputs synchronous to clk; 32-bit word register port.
module lvl_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int LOCAL_N = LOC_N,
    parameter int SEL_W = FSEL_W,
    parameter int ADDR_W = BYTE_AW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   periph_lvl,
    input  logic [LOCAL_N-1:0]    local_lvl,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_o,
    output logic                  fiq_o
);
    localparam int PERIPH_N = 2 * DATA_W;

    logic [PERIPH_N-1:0] pen_q, pen_d;
    logic [LOCAL_N-1:0]  len_q, len_d;
    logic                fen_q, fen_d;
    logic [SEL_W-1:0]    fsel_q, fsel_d;

    irqc_mask_regs #(
        .DATA_W(DATA_W), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata),
        .pen_q(pen_q), .len_q(len_q), .fen_q(fen_q), .fsel_q(fsel_q),
        .pen_d(pen_d), .len_d(len_d), .fen_d(fen_d), .fsel_d(fsel_d)
    );

    irqc_read_mux #(
        .DATA_W(DATA_W), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
    ) u_rd (
        .addr(bus_addr), .plvl(periph_lvl), .llvl(local_lvl),
        .pen_q(pen_q), .len_q(len_q), .fen_q(fen_q), .fsel_q(fsel_q),
        .rdata(bus_rdata)
    );

    irqc_out_stage #(
        .PERIPH_N(PERIPH_N), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W)
    ) u_out (
        .clk(clk), .rst_n(rst_n), .plvl(periph_lvl), .llvl(local_lvl),
        .pen_d(pen_d), .len_d(len_d), .fen_d(fen_d), .fsel_d(fsel_d),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );
endmodule

// File: tb/lvl_irq_ctrl_tb.sv
// Scoreboard bench: the driver computes expected outputs from a bench-side
// model and queues them; the monitor compares them after each clock edge.
module lvl_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  irq;
        logic  fiq;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] periph_lvl = '0;
    logic [7:0]  local_lvl = '0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int failures = 0;
    exp_t sb_q[$];

    // Bench model state
    logic [63:0] m_pen = '0;
    logic [7:0]  m_len = '0;
    logic        m_fen = 1'b0;
    logic [6:0]  m_fsel = '0;

    lvl_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .periph_lvl(periph_lvl),
        .local_lvl(local_lvl), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp_v,
                       input string tag);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp_v);
        end
    endtask

    function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
        if (a[1:0] != 2'b00) return;
        case (a[8:2])
            7'd3: begin m_fsel = d[6:0]; m_fen = d[7]; end
            7'd4: m_pen[31:0]  = m_pen[31:0]  | d;
            7'd5: m_pen[63:32] = m_pen[63:32] | d;
            7'd6: m_len = m_len | d[7:0];
            7'd7: m_pen[31:0]  = m_pen[31:0]  & ~d;
            7'd8: m_pen[63:32] = m_pen[63:32] & ~d;
            7'd9: m_len = m_len & ~d[7:0];
            default: ;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [8:0] a);
        logic [63:0] pp;
        logic [31:0] r;
        int mir [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
        pp = periph_lvl & m_pen;
        r = '0;
        if (a[1:0] != 2'b00) return '0;
        case (a[8:2])
            7'd0: begin
                r[7:0] = local_lvl & m_len;
                r[8] = |pp[31:0];
                r[9] = |pp[63:32];
                for (int i = 0; i < 11; i++) r[10+i] = pp[mir[i]];
            end
            7'd1: r = pp[31:0];
            7'd2: r = pp[63:32];
            7'd3: r = {24'd0, m_fen, m_fsel};
            7'd4: r = m_pen[31:0];
            7'd5: r = m_pen[63:32];
            7'd6: r = {24'd0, m_len};
            7'd7: r = ~m_pen[31:0];
            7'd8: r = ~m_pen[63:32];
            7'd9: r = ~{24'd0, m_len};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic model_fiq();
        if (!m_fen) return 1'b0;
        if (m_fsel < 7'd64) return periph_lvl[m_fsel[5:0]];
        if (m_fsel < 7'd72) return local_lvl[m_fsel[2:0]];
        return 1'b0;
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected outputs
    task automatic step(input logic wr, input logic [8:0] a, input logic [31:0] d,
                        input logic [63:0] pl, input logic [7:0] ll, input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        periph_lvl = pl; local_lvl = ll;
        if (wr) model_write(a, d);
        e.irq = (|(pl & m_pen)) | (|(ll & m_len));
        e.fiq = model_fiq();
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 chk(bus_rdata, model_read(a), tag);
    endtask

    // Monitor: compare outputs just after each edge against queued items
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({31'd0, irq_o}, {31'd0, e.irq}, {e.tag, " irq"});
            chk({31'd0, fiq_o}, {31'd0, e.fiq}, {e.tag, " fiq"});
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] pl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk({31'd0, irq_o}, 32'd0, "R11 irq after reset");
        chk({31'd0, fiq_o}, 32'd0, "R11 fiq after reset");
        rst_n = 1'b1;
        rd(9'h010, "R11 enable low cleared");
        rd(9'h00C, "R11 fast control cleared");
        rd(9'h01C, "R4 inverse of empty mask");

        pl = (64'd1 << 0) | (64'd1 << 7) | (64'd1 << 40) | (64'd1 << 53) | (64'd1 << 62);
        step(1'b0, 9'h000, 32'd0, pl, 8'h41, "R1 levels with empty masks");
        step(1'b1, 9'h010, 32'h0000_0081, pl, 8'h41, "R2 set low");
        rd(9'h004, "R5 pending low");
        rd(9'h010, "R4 enable low read");
        rd(9'h01C, "R4 disable low read");
        step(1'b1, 9'h014, (32'd1 << 8) | (32'd1 << 21) | (32'd1 << 30), pl, 8'h41,
             "R2 set high");
        rd(9'h008, "R5 pending high");
        rd(9'h000, "R6 summary banks and mirrors");
        step(1'b1, 9'h018, 32'h0000_01FF, pl, 8'h41, "R2 set local");
        rd(9'h018, "R2 local only low 8 bits");
        rd(9'h024, "R4 disable local read");
        rd(9'h000, "R6 summary with local");
        step(1'b1, 9'h01C, 32'hFFFF_FFFF, pl, 8'h41, "R3 clear low");
        rd(9'h010, "R3 low mask empty");
        rd(9'h000, "R6 summary low flag off");
        step(1'b1, 9'h020, 32'hFFFF_FFFF, pl, 8'h41, "R3 clear high");
        step(1'b1, 9'h024, 32'h0000_0041, pl, 8'h41, "R3 clear local bits 0 and 6");
        rd(9'h018, "R3 local mask after clear");

        // R10: output must not move before the edge, then move after it
        @(negedge clk);
        local_lvl = 8'h42;
        #1 chk({31'd0, irq_o}, 32'd0, "R10 irq unchanged before edge");
        step(1'b0, 9'h000, 32'd0, pl, 8'h42, "R10 irq after one edge");

        step(1'b1, 9'h00C, 32'h80 | 32'd70, pl, 8'h42, "R8 fast on local 6 unmasked");
        rd(9'h00C, "R7 fast control readback");
        step(1'b1, 9'h00C, 32'h80 | 32'd40, pl, 8'h42, "R8 fast on peripheral 40");
        step(1'b1, 9'h00C, 32'h80 | 32'd41, pl, 8'h42, "R8 fast on clear peripheral 41");
        step(1'b1, 9'h00C, 32'h80 | 32'd72, '1, 8'hFF, "R9 select 72");
        step(1'b1, 9'h00C, 32'h80 | 32'd127, '1, 8'hFF, "R9 select 127");
        step(1'b1, 9'h00C, 32'd40, pl, 8'h42, "R8 fast route disabled");
        rd(9'h00C, "R7 readback with enable clear");

        // R12 stray writes
        step(1'b1, 9'h028, 32'hFFFF_FFFF, pl, 8'h42, "R12 unmapped write");
        step(1'b1, 9'h011, 32'hFFFF_FFFF, pl, 8'h42, "R12 misaligned write");
        step(1'b1, 9'h004, 32'hFFFF_FFFF, pl, 8'h42, "R12 pending write");
        step(1'b1, 9'h000, 32'hFFFF_FFFF, pl, 8'h42, "R12 summary write");
        rd(9'h010, "R12 low mask unchanged");
        rd(9'h014, "R12 high mask unchanged");
        rd(9'h018, "R12 local mask unchanged");
        rd(9'h00C, "R12 fast control unchanged");
        rd(9'h028, "R12 unmapped read zero");
        rd(9'h1FC, "R12 top word read zero");
        rd(9'h012, "R12 misaligned read zero");

        // R11 reset in mid-run
        step(1'b1, 9'h014, 32'hFFFF_FFFF, pl, 8'h42, "R2 refill high");
        step(1'b1, 9'h00C, 32'h80 | 32'd40, pl, 8'h42, "R8 fast on before reset");
        @(negedge clk);
        rst_n = 1'b0;
        m_pen = '0; m_len = '0; m_fen = 1'b0; m_fsel = '0;
        begin
            exp_t e;
            e.irq = 1'b0; e.fiq = 1'b0; e.tag = "R11 outputs cleared by reset";
            sb_q.push_back(e);
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        rd(9'h014, "R11 high mask cleared");
        rd(9'h00C, "R11 fast control cleared again");
        rd(9'h000, "R11 summary zero after reset");

        repeat (2) @(posedge clk);
        #2;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule